// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD registers: seconds, minutes, hours, day of month, month, day of week and a two-digit year. A fractional-second strobe drives it. A small prescaler turns each group of `SUBTICKS` strobes into one second. A carry sequencer then moves the second boundary up through the fields, one field per clock cycle. The sequencer stops at the first field that does not wrap. The hour field runs in a 24-hour format or in a 12-hour format with a PM flag. The day-of-month field wraps at the true end of each month, and February follows the leap-year rule.

An external host interface loads any field through a one-cycle write port. It reads any field through a combinational read port addressed by a 3-bit index. Mode and status flags live in the spare upper bits of the time bytes. These are the halt flag in the seconds byte, and the 12-hour select and PM flag in the hours byte. Bits that no field uses read back as zero.

The carry sequencer is a state machine with states IDLE, SEC, MIN, HOUR, DATE, MONTH and YEAR:

| From | To | Condition |
|---|---|---|
| IDLE | SEC | The prescaler reports a finished second, the halt flag is clear and no write is under way. |
| SEC | MIN | Seconds wrap. |
| MIN | HOUR | Minutes wrap. |
| HOUR | DATE | The day rolls over. |
| DATE | MONTH | The day of month wraps. |
| MONTH | YEAR | December rolls over. |
| YEAR | IDLE | Always. |
| Any other state | IDLE | The field does not wrap. |
| Any state | IDLE | A write arrives; the ripple in progress is abandoned. |

Each state other than IDLE steps its own field during the cycle the state machine is in that state.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds (address 0, bits 6:0) and minutes (address 1, bits 6:0) count 00 to 59 in BCD. Stepping from 59 gives 00 and carries into the next field.
- R2: While bit 7 of the seconds byte (the halt flag) is 1, no field advances however many strobes arrive. Clearing the flag resumes counting.
- R3: With bit 7 of the hours byte (address 2) at 0, the block is in 24-hour mode. Bits 5:0 count 00 to 23 in BCD, and 23 wraps to 00 with a day carry.
- R4: With bit 7 of the hours byte at 1, the block is in 12-hour mode. Bits 4:0 count 01 to 12 in BCD and bit 5 is the PM flag (1 = PM). Going from 11 to 12 toggles the flag, and 12 goes to 01. The day advances only on the step from 11 PM to 12 AM.
- R5: Day of month (address 3) runs from 01, month (address 4) runs 01 to 12, weekday (address 5) runs 01 to 07 and year (address 6) runs 00 to 99, all in BCD. The weekday steps at the same moment as the day of month and wraps from 07 to 01 on its own.
- R6: Day 30 is the last day of April, June, September and November, and day 31 is the last day of the other months except February. February ends on day 28, or day 29 when the year is a multiple of 4 (00 counts as a leap year).
- R7: A write with `wr_en` high loads `wr_data` into the field selected by `wr_addr`. `rd_data` shows the field selected by `rd_addr` in the same cycle. After reset the fields read 00, 00, 00, 01, 01, 01, 00 for addresses 0 to 6.
- R8: Unused bits always read 0. These are minutes bit 7, hours bit 6, day-of-month bits 7:6, month bits 7:5 and weekday bits 7:3. Address 7 reads 00.
- R9: The seconds field steps once for every `SUBTICKS` strobes (default 4). A write to the seconds address restarts the count of strobes, so the next step needs a further `SUBTICKS` strobes.
- R10: The seconds field changes on the second clock edge after the edge that samples the completing strobe. A carry reaches each higher field one cycle after the field below it. A write returns the sequencer to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sub_tick | input | 1 | Fractional-second strobe, one cycle wide |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field index for a write |
| wr_data | input | 8 | Byte to load |
| rd_addr | input | 3 | Field index for a read |
| rd_data | output | 8 | Selected field, unused bits zero |

## Verification
The hardest cases to reach from the ports are the full ripples. One is 23:59:59, or 11:59:59 PM, on the last day of a month, which has to carry all the way into the month field and on into the year. The other is the leap-day boundary in February, which needs a matching year. Waiting for these to happen naturally would take simulated days. The stimulus instead loads the fields directly to a few seconds before such a boundary and then issues complete groups of strobes. The random cases are weighted toward seconds 55 to 59, minute 59, hours 11 and 23, and the last day of the month. Directed cases cover leap and non-leap Februaries, the 30-day months and the turn of the century, and they also check the halt flag, the prescaler restart and the exact update cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEC,
        ST_MIN,
        ST_HOUR,
        ST_DATE,
        ST_MONTH,
        ST_YEAR
    } carry_state_e;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_SEC   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_MIN   = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_HOUR  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_DATE  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_MONTH = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_WDAY  = 3'd5;
    localparam logic [ADDR_W-1:0] ADDR_YEAR  = 3'd6;

    // two-digit BCD increment without range limit
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // BCD year multiple of four: (10*t + u) mod 4 == (2*t + u) mod 4
    function automatic logic bcd_leap(input logic [7:0] y);
        logic [1:0] s;
        s = {y[4], 1'b0} + y[1:0];
        return (s == 2'd0);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
    parameter int SUBTICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sub_tick,
    input  logic run,
    input  logic clear,
    output logic sec_pulse
);
    generate
        if (SUBTICKS <= 1) begin : g_direct
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sec_pulse <= 1'b0;
                else        sec_pulse <= sub_tick && run && !clear;
            end
        end else begin : g_count
            localparam int CW = $clog2(SUBTICKS);
            localparam logic [CW-1:0] LAST = CW'(SUBTICKS - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q     <= '0;
                    sec_pulse <= 1'b0;
                end else begin
                    sec_pulse <= 1'b0;
                    if (clear) begin
                        cnt_q <= '0;
                    end else if (sub_tick && run) begin
                        if (cnt_q == LAST) begin
                            cnt_q     <= '0;
                            sec_pulse <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            end
        end
    endgenerate

    a_r2_halt_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sec_pulse);
    a_r9_clear_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !sec_pulse);

endmodule

// File: rtl/rtc_carry_fsm.sv
module rtc_carry_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sec_pulse,
    input  logic halt,
    input  logic wr_en,
    input  logic sec_wrap,
    input  logic min_wrap,
    input  logic day_carry,
    input  logic date_wrap,
    input  logic mon_wrap,
    output logic step_sec,
    output logic step_min,
    output logic step_hour,
    output logic step_date,
    output logic step_month,
    output logic step_year
);
    carry_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = (sec_pulse && !halt) ? ST_SEC : ST_IDLE;
            ST_SEC:   state_d = sec_wrap  ? ST_MIN   : ST_IDLE;
            ST_MIN:   state_d = min_wrap  ? ST_HOUR  : ST_IDLE;
            ST_HOUR:  state_d = day_carry ? ST_DATE  : ST_IDLE;
            ST_DATE:  state_d = date_wrap ? ST_MONTH : ST_IDLE;
            ST_MONTH: state_d = mon_wrap  ? ST_YEAR  : ST_IDLE;
            ST_YEAR:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (wr_en) state_d = ST_IDLE;
    end

    always_comb begin
        step_sec   = 1'b0;
        step_min   = 1'b0;
        step_hour  = 1'b0;
        step_date  = 1'b0;
        step_month = 1'b0;
        step_year  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SEC:   step_sec   = !wr_en;
            ST_MIN:   step_min   = !wr_en;
            ST_HOUR:  step_hour  = !wr_en;
            ST_DATE:  step_date  = !wr_en;
            ST_MONTH: step_month = !wr_en;
            ST_YEAR:  step_year  = !wr_en;
            default:  ;
        endcase
    end

    a_r10_write_abort: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> state_q == ST_IDLE);
    a_r10_ripple_order: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_MIN |-> $past(state_q) == ST_SEC);
    a_r2_halt_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && halt) |=> state_q == ST_IDLE);

endmodule

// File: rtl/rtc_fields.sv
module rtc_fields
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step_sec,
    input  logic              step_min,
    input  logic              step_hour,
    input  logic              step_date,
    input  logic              step_month,
    input  logic              step_year,
    output logic [DATA_W-1:0] sec_q,
    output logic [DATA_W-1:0] min_q,
    output logic [DATA_W-1:0] hour_q,
    output logic [DATA_W-1:0] date_q,
    output logic [DATA_W-1:0] mon_q,
    output logic [DATA_W-1:0] wday_q,
    output logic [DATA_W-1:0] year_q,
    output logic              halt,
    output logic              sec_wrap,
    output logic              min_wrap,
    output logic              day_carry,
    output logic              date_wrap,
    output logic              mon_wrap
);
    logic       mode12;
    logic [7:0] hour_next;

    assign halt      = sec_q[7];
    assign mode12    = hour_q[7];
    assign sec_wrap  = (sec_q[6:0] == 7'h59);
    assign min_wrap  = (min_q[6:0] == 7'h59);
    assign day_carry = mode12 ? (hour_q[5] && hour_q[4:0] == 5'h11)
                              : (hour_q[5:0] == 6'h23);
    assign date_wrap = (date_q == month_last(mon_q, bcd_leap(year_q)));
    assign mon_wrap  = (mon_q == 8'h12);

    always_comb begin
        if (mode12) begin
            if (hour_q[4:0] == 5'h11)      hour_next = {2'b10, ~hour_q[5], 5'h12};
            else if (hour_q[4:0] == 5'h12) hour_next = {2'b10, hour_q[5], 5'h01};
            else                           hour_next = {2'b10, hour_q[5], bcd_inc({3'b0, hour_q[4:0]})[4:0]};
        end else begin
            if (hour_q[5:0] == 6'h23)      hour_next = 8'h00;
            else                           hour_next = {2'b00, bcd_inc({2'b0, hour_q[5:0]})[5:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q  <= 8'h00;
            min_q  <= 8'h00;
            hour_q <= 8'h00;
            date_q <= 8'h01;
            mon_q  <= 8'h01;
            wday_q <= 8'h01;
            year_q <= 8'h00;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_SEC:   sec_q  <= wr_data;
                ADDR_MIN:   min_q  <= {1'b0, wr_data[6:0]};
                ADDR_HOUR:  hour_q <= {wr_data[7], 1'b0, wr_data[5:0]};
                ADDR_DATE:  date_q <= {2'b0, wr_data[5:0]};
                ADDR_MONTH: mon_q  <= {3'b0, wr_data[4:0]};
                ADDR_WDAY:  wday_q <= {5'b0, wr_data[2:0]};
                ADDR_YEAR:  year_q <= wr_data;
                default:    ;
            endcase
        end else begin
            if (step_sec)   sec_q  <= sec_wrap ? {sec_q[7], 7'h00} : {sec_q[7], bcd_inc({1'b0, sec_q[6:0]})[6:0]};
            if (step_min)   min_q  <= min_wrap ? 8'h00 : bcd_inc(min_q);
            if (step_hour)  hour_q <= hour_next;
            if (step_date) begin
                date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);
                wday_q <= (wday_q[2:0] == 3'd7) ? 8'h01 : {5'b0, wday_q[2:0] + 3'd1};
            end
            if (step_month) mon_q  <= mon_wrap ? 8'h01 : bcd_inc(mon_q);
            if (step_year)  year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
        end
    end

    a_r1_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_sec && !wr_en && sec_q[6:0] == 7'h59) |=> sec_q[6:0] == 7'h00);
    a_r5_wday_range: assert property (@(posedge clk) disable iff (!rst_n)
        (step_date && !wr_en) |=> (wday_q >= 8'h01 && wday_q <= 8'h07));
    a_r6_leap_day: assert property (@(posedge clk) disable iff (!rst_n)
        (step_date && !wr_en && mon_q == 8'h02 && date_q == 8'h28 && bcd_leap(year_q))
        |=> date_q == 8'h29);
    a_r4_pm_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (step_hour && !wr_en && mode12 && hour_q[4:0] == 5'h11)
        |=> hour_q[5] != $past(hour_q[5]));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int SUBTICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] sec_q, min_q, hour_q, date_q, mon_q, wday_q, year_q;
    logic halt, sec_pulse;
    logic sec_wrap, min_wrap, day_carry, date_wrap, mon_wrap;
    logic step_sec, step_min, step_hour, step_date, step_month, step_year;

    rtc_subsec #(.SUBTICKS(SUBTICKS)) u_subsec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_tick  (sub_tick),
        .run       (!halt),
        .clear     (wr_en && wr_addr == ADDR_SEC),
        .sec_pulse (sec_pulse)
    );

    rtc_carry_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_pulse  (sec_pulse),
        .halt       (halt),
        .wr_en      (wr_en),
        .sec_wrap   (sec_wrap),
        .min_wrap   (min_wrap),
        .day_carry  (day_carry),
        .date_wrap  (date_wrap),
        .mon_wrap   (mon_wrap),
        .step_sec   (step_sec),
        .step_min   (step_min),
        .step_hour  (step_hour),
        .step_date  (step_date),
        .step_month (step_month),
        .step_year  (step_year)
    );

    rtc_fields u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .step_sec   (step_sec),
        .step_min   (step_min),
        .step_hour  (step_hour),
        .step_date  (step_date),
        .step_month (step_month),
        .step_year  (step_year),
        .sec_q      (sec_q),
        .min_q      (min_q),
        .hour_q     (hour_q),
        .date_q     (date_q),
        .mon_q      (mon_q),
        .wday_q     (wday_q),
        .year_q     (year_q),
        .halt       (halt),
        .sec_wrap   (sec_wrap),
        .min_wrap   (min_wrap),
        .day_carry  (day_carry),
        .date_wrap  (date_wrap),
        .mon_wrap   (mon_wrap)
    );

    always_comb begin
        unique case (rd_addr)
            ADDR_SEC:   rd_data = sec_q;
            ADDR_MIN:   rd_data = min_q;
            ADDR_HOUR:  rd_data = hour_q;
            ADDR_DATE:  rd_data = date_q;
            ADDR_MONTH: rd_data = mon_q;
            ADDR_WDAY:  rd_data = wday_q;
            ADDR_YEAR:  rd_data = year_q;
            default:    rd_data = '0;
        endcase
    end

    a_r8_spare_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (min_q[7] == 1'b0) && (hour_q[6] == 1'b0) && (date_q[7:6] == 2'b00)
        && (mon_q[7:5] == 3'b000) && (wday_q[7:3] == 5'b00000));

endmodule

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;
    localparam int SUBTICKS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_sec, m_min, m_h24, m_date, m_mon, m_wd, m_yr;
    bit m12;

    always #2.5 clk = ~clk;

    rtc_calendar_core #(.SUBTICKS(SUBTICKS)) dut (
        .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int days_in(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] hour_byte(input int h24, input bit twelve);
        int h12;
        if (!twelve) return bcd(h24);
        h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
        return {1'b1, 1'b0, (h24 >= 12), bcd(h12)[4:0]};
    endfunction

    function automatic logic [7:0] exp_byte(input int a);
        case (a)
            0: return bcd(m_sec);
            1: return bcd(m_min);
            2: return hour_byte(m_h24, m12);
            3: return bcd(m_date);
            4: return bcd(m_mon);
            5: return bcd(m_wd);
            6: return bcd(m_yr);
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_step();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_h24++;
                if (m_h24 == 24) begin
                    m_h24 = 0;
                    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
                    m_date++;
                    if (m_date > days_in(m_mon, m_yr)) begin
                        m_date = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1;
                            m_yr = (m_yr + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic strobe();
        @(negedge clk) sub_tick = 1'b1;
        @(negedge clk) sub_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic one_second();
        for (int i = 0; i < SUBTICKS; i++) strobe();
        repeat (10) @(negedge clk);
        model_step();
    endtask

    task automatic load_model();
        wr(3'd1, bcd(m_min));
        wr(3'd2, hour_byte(m_h24, m12));
        wr(3'd3, bcd(m_date));
        wr(3'd4, bcd(m_mon));
        wr(3'd5, bcd(m_wd));
        wr(3'd6, bcd(m_yr));
        wr(3'd0, bcd(m_sec));
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk(req, $sformatf("addr %0d", a), v, exp_byte(a));
        end
    endtask

    task automatic set_time(input int s, input int mi, input int h, input bit t12,
                            input int d, input int mo, input int w, input int y);
        m_sec = s; m_min = mi; m_h24 = h; m12 = t12;
        m_date = d; m_mon = mo; m_wd = w; m_yr = y;
        load_model();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset values
        m_sec = 0; m_min = 0; m_h24 = 0; m12 = 0;
        m_date = 1; m_mon = 1; m_wd = 1; m_yr = 0;
        check_all("R7 reset");

        // R8: unused bits read zero
        wr(3'd1, 8'hFF); rd(3'd1, v); chk("R8", "min spare", v, 8'h7F);
        wr(3'd2, 8'hFF); rd(3'd2, v); chk("R8", "hour spare", v, 8'hBF);
        wr(3'd3, 8'hFF); rd(3'd3, v); chk("R8", "date spare", v, 8'h3F);
        wr(3'd4, 8'hFF); rd(3'd4, v); chk("R8", "month spare", v, 8'h1F);
        wr(3'd5, 8'hFF); rd(3'd5, v); chk("R8", "wday spare", v, 8'h07);
        rd(3'd7, v); chk("R8", "addr 7", v, 8'h00);

        // R1, R3, R5: 24h full ripple to new year
        set_time(59, 59, 23, 0, 31, 12, 7, 99);
        one_second(); check_all("R1 R3 R5 year rollover");

        // R6: leap and plain February, 30-day month
        set_time(59, 59, 23, 0, 28, 2, 3, 24);
        one_second(); check_all("R6 leap feb 28");
        set_time(59, 59, 23, 0, 29, 2, 4, 0);
        one_second(); check_all("R6 leap feb 29 year 00");
        set_time(59, 59, 23, 0, 28, 2, 3, 23);
        one_second(); check_all("R6 plain feb");
        set_time(59, 59, 23, 0, 30, 4, 2, 10);
        one_second(); check_all("R6 april 30");

        // R4: 12-hour transitions
        set_time(59, 59, 11, 1, 15, 6, 2, 10);
        one_second(); check_all("R4 11AM to 12PM");
        set_time(59, 59, 12, 1, 15, 6, 2, 10);
        one_second(); check_all("R4 12PM to 01PM");
        set_time(59, 59, 23, 1, 30, 6, 2, 10);
        one_second(); check_all("R4 11PM to 12AM carry");

        // R2: halt flag freezes time
        set_time(30, 10, 5, 0, 10, 3, 1, 20);
        wr(3'd0, 8'hB0);
        for (int i = 0; i < 2 * SUBTICKS; i++) strobe();
        repeat (10) @(negedge clk);
        rd(3'd0, v); chk("R2", "halted sec", v, 8'hB0);
        rd(3'd1, v); chk("R2", "halted min", v, 8'h10);
        wr(3'd0, 8'h30);
        one_second(); check_all("R2 resume");

        // R9: write to seconds restarts the strobe count
        set_time(20, 0, 1, 0, 1, 1, 1, 1);
        strobe(); strobe();
        wr(3'd0, bcd(20));
        for (int i = 0; i < SUBTICKS - 1; i++) strobe();
        repeat (10) @(negedge clk);
        rd(3'd0, v); chk("R9", "sec before full group", v, 8'h20);
        strobe(); repeat (10) @(negedge clk);
        rd(3'd0, v); chk("R9", "sec after full group", v, 8'h21);

        // R10: exact update cycle
        set_time(40, 0, 1, 0, 1, 1, 1, 1);
        @(negedge clk) rd_addr = 3'd0;
        for (int i = 0; i < SUBTICKS - 1; i++) strobe();
        @(negedge clk) sub_tick = 1'b1;
        @(negedge clk) sub_tick = 1'b0;
        @(negedge clk); #1 chk("R10", "one edge after strobe", rd_data, 8'h40);
        @(negedge clk); #1 chk("R10", "two edges after strobe", rd_data, 8'h41);

        // random cases near boundaries (R1 R3 R4 R5 R6)
        for (int it = 0; it < 40; it++) begin
            int secs;
            m12 = $urandom % 2;
            m_sec = 55 + $urandom % 5;
            m_min = ($urandom % 2) ? 59 : $urandom % 60;
            case ($urandom % 4)
                0: m_h24 = 23;
                1: m_h24 = 11;
                default: m_h24 = $urandom % 24;
            endcase
            m_yr = $urandom % 100;
            m_mon = 1 + $urandom % 12;
            m_date = ($urandom % 2) ? days_in(m_mon, m_yr) : 1 + $urandom % days_in(m_mon, m_yr);
            m_wd = 1 + $urandom % 7;
            load_model();
            secs = 1 + $urandom % 6;
            for (int s = 0; s < secs; s++) one_second();
            check_all("R1 R3 R4 R5 R6 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule